// File: doc/BRIEF.md
# Reset-Gated Memory Chip-Enable Controller

This block sits between a processor's active-low memory chip enable and an external battery-backed SRAM. While the system supervisor holds its reset indication low, the incoming enable is handed straight through to the memory. When the supervisor raises reset, as it does during a brown-out, the block closes the path and drives the memory enable high. This stops half-powered logic from writing garbage into the memory.

A write that is already under way when reset arrives is given a short grace window. The output stays low until the processor releases the enable or the window runs out, whichever comes first. From the moment the path closes it stays closed for a fixed blocking interval, whatever the input does. After that interval it reopens at the first clock edge that sees reset released.

The analog pass gate is modelled as a combinational pass-through. The output pull-up is modelled as a separate drive-high indication. The enable path is a plain level signal with no valid/ready flow control. It cannot be stalled, so no back-pressure rules apply.

Top module: `ce_guard`

## Requirements
- R1: With the path open and `sup_rst` low, `ce_out_n` equals `ce_in_n` in the same cycle, with no register in between.
- R2: If `sup_rst` is high while the path is open and `ce_in_n` is high (inactive), the path closes in that same cycle: `pass_en` falls to 0 and `ce_out_n` becomes 1 before the next rising edge.
- R3: If `sup_rst` is first sampled high while `ce_in_n` is low, the output keeps following the input. It stops doing so in the cycle in which `ce_in_n` rises. If the input never rises, the path closes at the rising edge that comes `GRACE_CYC` edges after the first edge that sampled reset.
- R4: Once the path has closed, it stays closed for at least `BLOCK_CYC` rising edges after the closing edge. During that time every change on `ce_in_n` is ignored, and `ce_out_n` stays 1.
- R5: Whenever the path is closed, `ce_out_n` is 1.
- R6: `drive_hi` is 1 exactly when the path is closed and 0 whenever the path is open.
- R7: The path reopens at the first rising edge at which the blocking interval is complete and `sup_rst` is sampled low. A reset that drops during the grace window or the blocking interval does not shorten either one.
- R8: `pass_en` is 1 exactly in the cycles in which `ce_in_n` is passed to `ce_out_n`.
- R9: After `rst_n` is released, the path is open.
- R10: `BLOCK_CYC` must be smaller than the supervisor timeout parameter `SUP_TIMEOUT_CYC`. Any other setting is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| sup_rst | input | 1 | Supervisor reset indication, active high |
| ce_in_n | input | 1 | Incoming memory chip enable, active low |
| ce_out_n | output | 1 | Gated memory chip enable, active low |
| pass_en | output | 1 | 1 while the input is passed to the output |
| drive_hi | output | 1 | 1 while the output is actively pulled high |

## Verification
The immediate closure (R2) and the release of the grace window on a rising input (R3) are combinational, so they are checked one time unit after the stimulus, inside the same cycle. The end of the grace window falls `GRACE_CYC` edges after the first edge that samples reset. Reopening falls at the later of two edges: `BLOCK_CYC` edges after closure, or the edge after `sup_rst` drops. The bench computes both edge numbers arithmetically for every scenario in a sweep over the release point of the input and the moment reset drops. Inputs are driven, and outputs are sampled, at the falling edge. Each sample is therefore compared with the state left by the preceding rising edge.

// File: rtl/ce_guard_pkg.sv
package ce_guard_pkg;
  typedef enum logic [1:0] {
    ST_OPEN  = 2'd0,
    ST_GRACE = 2'd1,
    ST_BLOCK = 2'd2,
    ST_REARM = 2'd3
  } gate_state_t;
endpackage

// File: rtl/ce_guard_cnt.sv
module ce_guard_cnt #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic done
);
  localparam int W = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (clr)             cnt <= '0;
    else if (en && cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign done = (cnt == LAST);
endmodule

// File: rtl/ce_guard_fsm.sv
module ce_guard_fsm
  import ce_guard_pkg::*;
#(
  parameter int GRACE_CYC = 4,
  parameter int BLOCK_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_rst,
  input  logic ce_in_n,
  output logic pass_en
);
  gate_state_t st, st_nxt;
  logic grace_done, block_done;

  ce_guard_cnt #(.LIMIT(GRACE_CYC)) u_grace (
    .clk(clk), .rst_n(rst_n),
    .clr(st != ST_GRACE), .en(st == ST_GRACE),
    .done(grace_done)
  );

  ce_guard_cnt #(.LIMIT(BLOCK_CYC)) u_block (
    .clk(clk), .rst_n(rst_n),
    .clr(st != ST_BLOCK), .en(st == ST_BLOCK),
    .done(block_done)
  );

  always_comb begin
    st_nxt = st;
    case (st)
      ST_OPEN:  if (sup_rst) st_nxt = ce_in_n ? ST_BLOCK : ST_GRACE;
      ST_GRACE: if (ce_in_n || grace_done) st_nxt = ST_BLOCK;
      ST_BLOCK: if (block_done) st_nxt = sup_rst ? ST_REARM : ST_OPEN;
      ST_REARM: if (!sup_rst) st_nxt = ST_OPEN;
      default:  st_nxt = ST_BLOCK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_OPEN;
    else        st <= st_nxt;
  end

  // Pass while open (unless an idle enable meets reset) or during grace while still low.
  assign pass_en = ((st == ST_OPEN)  && !(sup_rst && ce_in_n)) ||
                   ((st == ST_GRACE) && !ce_in_n);

  // Run length of passing while reset is high; bounds the grace window.
  localparam int GW = $clog2(GRACE_CYC + 2);
  logic [GW-1:0] grace_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       grace_run <= '0;
    else if (!(pass_en && sup_rst))   grace_run <= '0;
    else if (grace_run != GW'(GRACE_CYC + 1)) grace_run <= grace_run + 1'b1;
  end

  assert_grace_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_en && sup_rst) |-> (grace_run <= GW'(GRACE_CYC)));

  assert_no_early_reopen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass_en) |-> $past(!sup_rst));

  assert_blocked_state_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_BLOCK || st == ST_REARM) |-> !pass_en);
endmodule

// File: rtl/ce_guard_mux.sv
module ce_guard_mux (
  input  logic pass_en,
  input  logic ce_in_n,
  output logic ce_out_n,
  output logic drive_hi
);
  assign drive_hi = !pass_en;
  assign ce_out_n = pass_en ? ce_in_n : 1'b1;
endmodule

// File: rtl/ce_guard.sv
module ce_guard #(
  parameter int GRACE_CYC       = 4,
  parameter int BLOCK_CYC       = 16,
  parameter int SUP_TIMEOUT_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_rst,
  input  logic ce_in_n,
  output logic ce_out_n,
  output logic pass_en,
  output logic drive_hi
);
  if (BLOCK_CYC >= SUP_TIMEOUT_CYC || BLOCK_CYC < 1 || GRACE_CYC < 1) begin : g_bad_cfg_R10
    $error("ce_guard: BLOCK_CYC must be below SUP_TIMEOUT_CYC and counts must be positive");
  end

  logic pass_w;

  ce_guard_fsm #(.GRACE_CYC(GRACE_CYC), .BLOCK_CYC(BLOCK_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .sup_rst(sup_rst),
    .ce_in_n(ce_in_n), .pass_en(pass_w)
  );

  ce_guard_mux u_mux (
    .pass_en(pass_w), .ce_in_n(ce_in_n),
    .ce_out_n(ce_out_n), .drive_hi(drive_hi)
  );

  assign pass_en = pass_w;

  // Consecutive closed cycles, saturating at BLOCK_CYC.
  localparam int CW = $clog2(BLOCK_CYC + 1);
  logic [CW-1:0] closed_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        closed_run <= '0;
    else if (pass_en)                  closed_run <= '0;
    else if (closed_run != CW'(BLOCK_CYC)) closed_run <= closed_run + 1'b1;
  end

  assert_min_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass_en) |-> (closed_run == CW'(BLOCK_CYC)));

  assert_pull_gives_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    drive_hi |-> ce_out_n);

  assert_pull_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pass_en |-> !drive_hi);

  assert_follow_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_en && !sup_rst) |-> (ce_out_n == ce_in_n));
endmodule

// File: tb/sim_ce_guard.sv
`timescale 1ns/1ps
module sim_ce_guard;
  localparam int G = 3;
  localparam int B = 6;
  localparam int T = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sup_rst = 1'b0;
  logic ce_in_n = 1'b1;
  logic ce_out_n, pass_en, drive_hi;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ce_guard #(.GRACE_CYC(G), .BLOCK_CYC(B), .SUP_TIMEOUT_CYC(T)) u0 (
    .clk(clk), .rst_n(rst_n), .sup_rst(sup_rst), .ce_in_n(ce_in_n),
    .ce_out_n(ce_out_n), .pass_en(pass_en), .drive_hi(drive_hi)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic int imin(input int a, input int b); return (a < b) ? a : b; endfunction
  function automatic int imax(input int a, input int b); return (a > b) ? a : b; endfunction

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R9", "pass_en after reset", pass_en, 1'b1);
    chk("R9", "drive_hi after reset", drive_hi, 1'b0);

    // R1: idle pass-through, toggling the enable
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); ce_in_n = i[0]; #1;
      chk("R1", "ce_out_n follows", ce_out_n, ce_in_n);
      chk("R8", "pass_en open", pass_en, 1'b1);
    end

    // Sweep: k = negedge at which the input rises, r = negedge at which reset drops
    for (int k = 0; k <= G + 2; k++) begin
      for (int r = 1; r <= G + B + 4; r++) begin
        int c, op, hold, last;
        c    = imin(k, G) + 1;          // edge entering the blocking interval
        op   = imax(c + B, r + 1);      // first sample with the path open again
        hold = imin(k, G + 1);          // samples 0..hold-1 still pass under reset
        last = op + 3;
        for (int n = 0; n <= last; n++) begin
          logic exp_pass, exp_out, cev;
          string tg;
          @(negedge clk);
          sup_rst = (n < r);
          cev = (n >= c) ? logic'(n[0]) : logic'(n >= k);
          ce_in_n = cev;
          #1;
          exp_pass = (n < hold) || (n >= op);
          exp_out  = exp_pass ? cev : 1'b1;
          if (n == 0 && k == 0)  tg = "R2";
          else if (n < hold)     tg = "R3";
          else if (n < op && n >= c && n < c + B) tg = "R4";
          else if (n < op)       tg = (n < c) ? "R3" : "R7";
          else                   tg = "R7";
          chk(tg, "pass_en", pass_en, exp_pass);
          chk(exp_pass ? "R1" : "R5", "ce_out_n", ce_out_n, exp_out);
          chk("R6", "drive_hi", drive_hi, !exp_pass);
          chk("R8", "pass vs output", pass_en && (ce_out_n !== cev), 1'b0);
        end
        @(negedge clk); ce_in_n = 1'b1;
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule